// File: doc/BRIEF.md
# Control-Word Register/ALU Datapath

This block is the execution core of a small processor: seven general-purpose registers share one arithmetic/logic unit, and every clock cycle a 13-bit control word steers the whole path. The word names the register that feeds operand A, the register that feeds operand B, the register that receives the result, and the operation. The sources are read and combined within the cycle, and the result is written back on the next rising clock edge.

A select code of zero has a special meaning. As an operand select it routes the external input bus into the ALU in place of a register, which is how constants and outside data enter the register file. As a destination select it suppresses the write, so a result can be inspected on the output bus without disturbing any register. The ALU result is always visible on the output bus, together with a flag that is high when the result is all zeros. Whatever produces the control words (a sequencer, a control store, an instruction decoder) sits outside this block.

Top module: `regalu_datapath`

## Requirements
- R1: An active-low asynchronous reset clears all seven registers to zero; after reset, reading any register with the pass operation shows zero on the output bus.
- R2: The control word is ordered {A select [12:10], B select [9:7], destination [6:4], opcode [3:0]}; an A or B select of 000 feeds the external input bus to that operand, and codes 001 to 111 select registers 1 to 7.
- R3: A destination of 001 to 111 loads the ALU result into that register on the rising clock edge; a destination of 000 loads no register.
- R4: Arithmetic opcodes, all modulo 2^DATA_W: 0000 passes A, 0001 gives A+1, 0010 gives A+B, 0011 gives A−B, 0100 gives A−1.
- R5: Logic opcodes: 0101 gives A AND B, 0110 gives A OR B, 0111 gives A XOR B, 1000 gives the bitwise complement of A.
- R6: Opcode 1001 shifts A right by one and opcode 1010 shifts A left by one; the vacated bit is filled with 0.
- R7: Opcodes 1011 to 1111 pass A unchanged.
- R8: The zero flag is high exactly when the ALU output bus is all zeros, including when no register is written.
- R9: The output bus is combinational: when the destination equals a source, the bus shows the result computed from the register's value before the edge.
- R10: A value written at an edge is the value read from that register in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| ctrl_word | input | 13 | Control word {A select, B select, destination, opcode} |
| ext_in | input | DATA_W | External input bus, used as an operand by select code 000 |
| alu_out | output | DATA_W | ALU result bus, combinational |
| zero_flag | output | 1 | High when alu_out is all zeros |

## Verification
Reading a register and writing that same register can fall in the same cycle whenever the destination select matches the A or B select. The bench provokes this with directed words such as incrementing register 3 into itself, and random words hit it often because all three selects are drawn from the same eight codes. It is judged by sampling the output bus before the edge, which must show the result built from the old value, and then reading the register in the next cycle, which must show the new value.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int SEL_W = 3;
    localparam int OP_W  = 4;
    localparam int CW_W  = 3 * SEL_W + OP_W;

    // Operation codes
    localparam logic [OP_W-1:0] OPC_PASS = 4'b0000;
    localparam logic [OP_W-1:0] OPC_INC  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD  = 4'b0010;
    localparam logic [OP_W-1:0] OPC_SUB  = 4'b0011;
    localparam logic [OP_W-1:0] OPC_DEC  = 4'b0100;
    localparam logic [OP_W-1:0] OPC_AND  = 4'b0101;
    localparam logic [OP_W-1:0] OPC_OR   = 4'b0110;
    localparam logic [OP_W-1:0] OPC_XOR  = 4'b0111;
    localparam logic [OP_W-1:0] OPC_NOT  = 4'b1000;
    localparam logic [OP_W-1:0] OPC_SHR  = 4'b1001;
    localparam logic [OP_W-1:0] OPC_SHL  = 4'b1010;

    // Select code that means "external bus" / "no write"
    localparam logic [SEL_W-1:0] SEL_NONE = '0;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } ctrl_t;

endpackage

// File: rtl/regalu_regfile.sv
module regalu_regfile
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NREG-1:0][DATA_W-1:0]  reg_q
);

    // One storage element per register, each with its own write decode.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [SEL_W-1:0] MY_CODE = SEL_W'(gi + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[gi] <= '0;
            end else if (wr_sel == MY_CODE) begin
                reg_q[gi] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/regalu_opsel.sv
module regalu_opsel
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 7
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic [DATA_W-1:0]            ext_bus,
    input  logic [NREG-1:0][DATA_W-1:0]  reg_q,
    output logic [DATA_W-1:0]            operand
);

    always_comb begin
        operand = ext_bus;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                operand = reg_q[i];
            end
        end
    end

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        unique case (op)
            OPC_PASS: result = opa;
            OPC_INC:  result = opa + ONE;
            OPC_ADD:  result = opa + opb;
            OPC_SUB:  result = opa - opb;
            OPC_DEC:  result = opa - ONE;
            OPC_AND:  result = opa & opb;
            OPC_OR:   result = opa | opb;
            OPC_XOR:  result = opa ^ opb;
            OPC_NOT:  result = ~opa;
            OPC_SHR:  result = {1'b0, opa[DATA_W-1:1]};
            OPC_SHL:  result = {opa[DATA_W-2:0], 1'b0};
            default:  result = opa;
        endcase
    end

    assign is_zero = ~|result;

endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] ext_in,
    output logic [DATA_W-1:0] alu_out,
    output logic              zero_flag
);

    ctrl_t                        cw;
    logic [NREG-1:0][DATA_W-1:0]  reg_q;
    logic [1:0][DATA_W-1:0]       opnd;
    logic [1:0][SEL_W-1:0]        src_sel;
    logic [DATA_W-1:0]            result;

    assign cw         = ctrl_t'(ctrl_word);
    assign src_sel[0] = cw.src_a;
    assign src_sel[1] = cw.src_b;

    regalu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cw.dst),
        .wr_data (result),
        .reg_q   (reg_q)
    );

    for (genvar gp = 0; gp < 2; gp++) begin : g_port
        regalu_opsel #(.DATA_W(DATA_W), .NREG(NREG)) u_sel (
            .sel     (src_sel[gp]),
            .ext_bus (ext_in),
            .reg_q   (reg_q),
            .operand (opnd[gp])
        );
    end

    regalu_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (cw.op),
        .opa     (opnd[0]),
        .opb     (opnd[1]),
        .result  (result),
        .is_zero (zero_flag)
    );

    assign alu_out = result;

endmodule

// File: rtl/regalu_checker.sv
module regalu_checker
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW_W-1:0]   ctrl_word,
    input logic [DATA_W-1:0] ext_in,
    input logic [DATA_W-1:0] alu_out,
    input logic              zero_flag
);

    logic [SEL_W-1:0]  c_a, c_b, c_d;
    logic [OP_W-1:0]   c_op;
    logic [DATA_W-1:0] ext_inc, ext_dbl;

    assign c_a     = ctrl_word[CW_W-1 -: SEL_W];
    assign c_b     = ctrl_word[CW_W-1-SEL_W -: SEL_W];
    assign c_d     = ctrl_word[OP_W+SEL_W-1 -: SEL_W];
    assign c_op    = ctrl_word[OP_W-1:0];
    assign ext_inc = ext_in + DATA_W'(1);
    assign ext_dbl = ext_in + ext_in;

    // R2: select 000 on A routes the external bus through a pass
    p_ext_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_a == SEL_NONE && c_op == OPC_PASS) |-> alu_out == ext_in);

    // R2: select 000 on both operands doubles the external bus on add
    p_ext_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_a == SEL_NONE && c_b == SEL_NONE && c_op == OPC_ADD) |-> alu_out == ext_dbl);

    // R4: increment of the external bus
    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_a == SEL_NONE && c_op == OPC_INC) |-> alu_out == ext_inc);

    // R3: a register not targeted keeps its value into the next cycle
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_a != SEL_NONE && c_op == OPC_PASS && c_d != c_a) |=>
        (!(c_a == $past(c_a) && c_op == OPC_PASS) || alu_out == $past(alu_out)));

    // R10: written value is read back in the next cycle
    p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_d != SEL_NONE) |=>
        (!(c_a == $past(c_d) && c_op == OPC_PASS) || alu_out == $past(alu_out)));

    // R8: zero flag agrees with the result bus
    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> alu_out == '0);

    p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_flag |-> alu_out != '0);

endmodule

bind regalu_datapath regalu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .ext_in    (ext_in),
    .alu_out   (alu_out),
    .zero_flag (zero_flag)
);

// File: tb/regalu_datapath_tb.sv
module regalu_datapath_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [12:0]  ctrl_word = '0;
    logic [W-1:0] ext_in = '0;
    logic [W-1:0] alu_out;
    logic         zero_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [W-1:0] model [1:7];

    always #10 clk = ~clk;  // 50 MHz

    regalu_datapath #(.DATA_W(W), .NREG(7)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .ext_in    (ext_in),
        .alu_out   (alu_out),
        .zero_flag (zero_flag)
    );

    function automatic logic [12:0] cw(int a, int b, int d, int op);
        return {3'(a), 3'(b), 3'(d), 4'(op)};
    endfunction

    function automatic logic [W-1:0] ref_alu(int op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            0:  return a;
            1:  return a + 1'b1;
            2:  return a + b;
            3:  return a - b;
            4:  return a - 1'b1;
            5:  return a & b;
            6:  return a | b;
            7:  return a ^ b;
            8:  return ~a;
            9:  return a >> 1;
            10: return a << 1;
            default: return a;
        endcase
    endfunction

    function automatic string op_tag(int op);
        if (op <= 4) return "R4";
        if (op <= 8) return "R5";
        if (op <= 10) return "R6";
        return "R7";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one control word, check the bus before the edge, then track writes.
    task automatic step(string tag, int a, int b, int d, int op, logic [W-1:0] ext);
        logic [W-1:0] va, vb, exp;
        @(negedge clk);
        ctrl_word = cw(a, b, d, op);
        ext_in    = ext;
        #5;
        va  = (a == 0) ? ext : model[a];
        vb  = (b == 0) ? ext : model[b];
        exp = ref_alu(op, va, vb);
        check(tag, alu_out, exp);
        check("R8", {{(W-1){1'b0}}, zero_flag}, {{(W-1){1'b0}}, exp == '0});
        @(posedge clk);
        if (d != 0) model[d] = exp;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 1; i <= 7; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 1; i <= 7; i++) step("R1", i, 0, 0, 0, 8'hA5);
        // R2/R3: load registers from the external bus
        for (int i = 1; i <= 7; i++) step("R2", 0, 0, i, 0, 8'(8'h10 + i));
        // R10: read back each loaded value
        for (int i = 1; i <= 7; i++) step("R10", i, 0, 0, 0, 8'h00);
        // R2: external bus on the B operand
        step("R2", 1, 0, 0, 2, 8'h05);
        // R3: destination 000 leaves register 2 untouched
        step("R3", 2, 0, 0, 1, 8'h00);
        step("R3", 2, 0, 0, 0, 8'h00);
        // R9: increment register 3 into itself, old value on the bus
        step("R9", 3, 0, 3, 1, 8'h00);
        step("R10", 3, 0, 0, 0, 8'h00);
        // R4: increment wrap and decrement wrap
        step("R4", 0, 0, 4, 0, 8'hFF);
        step("R4", 4, 0, 4, 1, 8'h00);
        step("R4", 4, 0, 0, 4, 8'h00);
        // R4/R8: subtracting a register from itself gives zero
        step("R4", 5, 5, 0, 3, 8'h00);
        // R5: complement and self-XOR
        step("R5", 0, 0, 0, 8, 8'h00);
        step("R5", 6, 6, 0, 7, 8'h00);
        step("R5", 0, 7, 0, 5, 8'hF0);
        step("R5", 0, 7, 0, 6, 8'hF0);
        // R6: shifts fill with zero at both ends
        step("R6", 0, 0, 0, 9, 8'h81);
        step("R6", 0, 0, 0, 10, 8'h81);
        // R7: unused opcodes pass A
        for (int op = 11; op <= 15; op++) step("R7", 0, 3, 0, op, 8'h5A);

        // Random words mixed over all fields
        for (int n = 0; n < 800; n++) begin
            int op;
            op = int'($urandom_range(0, 15));
            step(op_tag(op), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), op, 8'($urandom));
        end
        // Final sweep: every register matches the tracked state (R10)
        for (int i = 1; i <= 7; i++) step("R10", i, 0, 0, 0, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule